// File: doc/BRIEF.md
# Background Address-Line Walker for Shared RAM

This engine checks the wiring of a single-port synchronous RAM while other logic keeps using it. Each pulse on its start input triggers exactly one short step. The engine asks an arbiter for the RAM, saves the two words it is about to overwrite and writes two different patterns. One goes to a fixed base word. The other goes to the word whose address is the base plus a single set address bit. It reads both words back and then writes the saved values back before it lets the bus go. Because the two probed addresses differ in one address bit only, a stuck, open or shorted line on that bit makes both writes land in the same word, and the read-back of the base word shows it. A bad data line shows up as a mismatch of the pattern bits.

An index register selects the address bit for the current step. It starts at bit 0, moves up by one on every completed step and returns to 0 after the top bit. Each return to 0 marks the end of a full pass over the address bus, and the engine signals it with a one-cycle pulse. When the engine first finds a mismatch, it latches the bit index, the expected word and the word actually read, and it keeps them until reset. The restore writes are still carried out after a mismatch, so the other master always finds its data in place.

The RAM has a read latency of one cycle: an address presented with the write enable low returns its word on the read-data input in the following cycle.

Top module: `ramWalkChecker`

## Requirements
- R1: After reset, busReq, doneStep, passDone and failFlag are all low and the bit index is 0.
- R2: busReq goes high in the cycle after a start pulse is taken in the idle state. No RAM write is issued until busGnt has been seen high, and every write occurs while busGnt is high.
- R3: When a step completes, every RAM word holds the value it held before the step.
- R4: A fault-free step issues exactly four writes, in this order: PAT_A to BASE_ADDR, PAT_B to BASE_ADDR + (1 << k), the saved base word to BASE_ADDR, and the saved offset word to BASE_ADDR + (1 << k).
- R5: k starts at 0 and goes up by one per completed step. After the step with k = ADDR_W-1, k returns to 0, and passDone is high in the same cycle as that step's doneStep and in no other cycle.
- R6: A start pulse that arrives while a step is in progress is ignored. It neither lengthens the step nor starts a second step.
- R7: If the base word reads back as anything other than PAT_A (for example PAT_B, because an address line is stuck), failFlag sets and failBit, failExp and failAct capture k, PAT_A and the word read.
- R8: If the offset word reads back as anything other than PAT_B, or a data line corrupts the base read, the mismatch is flagged and captured in the same way, with the pattern that was expected.
- R9: failFlag and its captured fields keep the first fault's values until reset, even when later steps pass or fail.
- R10: Once busGnt has been taken, busReq stays high through both restore writes, whether or not a fault was found. It falls only in the cycle after the last restore write.
- R11: doneStep is a one-cycle pulse, and busReq is low in the cycle in which doneStep is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Request one test step |
| busReq | output | 1 | Request for exclusive RAM access |
| busGnt | input | 1 | Grant from the arbiter |
| ramAddr | output | ADDR_W | RAM word address |
| ramWdata | output | DATA_W | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRdata | input | DATA_W | RAM read data, valid one cycle after the address |
| doneStep | output | 1 | Pulse when a step has finished and the bus is released |
| passDone | output | 1 | Pulse when the step for the top address bit finishes |
| failFlag | output | 1 | Sticky fault indicator |
| failBit | output | KW | Address-bit index of the first fault |
| failExp | output | DATA_W | Expected word of the first fault |
| failAct | output | DATA_W | Word actually read at the first fault |

## Verification
The bench builds the engine with ADDR_W = 6, DATA_W = 8, BASE_ADDR = 0 and the patterns 0x00 and 0xFF. A full pass therefore takes six steps, which keeps both the wrap of the bit index and the passDone pulse within reach of a short directed run. The bench's RAM model can force one address line to zero, which makes the two probed words alias on exactly one step, and it can force one data bit high. These two faults exercise fault capture, the sticky fields and the restore that follows a fault.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  // Source of the word written to the RAM in a given cycle
  typedef enum logic [1:0] {
    WSEL_PAT_A  = 2'd0,
    WSEL_PAT_B  = 2'd1,
    WSEL_SAVE_B = 2'd2,
    WSEL_SAVE_O = 2'd3
  } wsel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic  selOff;   // address the offset word instead of the base word
    logic  we;       // write this cycle
    wsel_e wsel;     // write data source
    logic  capBase;  // latch read data as saved base word
    logic  capOff;   // latch read data as saved offset word
    logic  chkBase;  // compare read data against pattern A
    logic  chkOff;   // compare read data against pattern B
    logic  advance;  // step finished: move bit index
  } dpStrb_t;

endpackage

// File: rtl/rwcCtrl.sv
module rwcCtrl
  import rwc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    busGnt,
  output logic    busReq,
  output dpStrb_t strb
);

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_RDB, S_RDO, S_WRB, S_WRO,
    S_CKB, S_CKO, S_RSB, S_RSO, S_FIN
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: if (startPulse) stateD = S_REQ;
      S_REQ:  if (busGnt)     stateD = S_RDB;
      S_RDB:  stateD = S_RDO;
      S_RDO:  stateD = S_WRB;
      S_WRB:  stateD = S_WRO;
      S_WRO:  stateD = S_CKB;
      S_CKB:  stateD = S_CKO;
      S_CKO:  stateD = S_RSB;
      S_RSB:  stateD = S_RSO;
      S_RSO:  stateD = S_FIN;
      S_FIN:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  // Read data returns one cycle after its address, so each capture or
  // compare happens in the state after the matching read.
  always_comb begin
    strb = '0;
    unique case (stateQ)
      S_RDO: begin strb.selOff = 1'b1; strb.capBase = 1'b1; end
      S_WRB: begin strb.we = 1'b1; strb.wsel = WSEL_PAT_A; strb.capOff = 1'b1; end
      S_WRO: begin strb.selOff = 1'b1; strb.we = 1'b1; strb.wsel = WSEL_PAT_B; end
      S_CKO: begin strb.selOff = 1'b1; strb.chkBase = 1'b1; end
      S_RSB: begin strb.we = 1'b1; strb.wsel = WSEL_SAVE_B; strb.chkOff = 1'b1; end
      S_RSO: begin strb.selOff = 1'b1; strb.we = 1'b1; strb.wsel = WSEL_SAVE_O; end
      S_FIN: strb.advance = 1'b1;
      default: ;
    endcase
  end

  assign busReq = (stateQ != S_IDLE) && (stateQ != S_FIN);

  // R2: writes only under a grant
  assert_write_granted_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.we |-> (busGnt && busReq));

  // R11: single-cycle completion pulse, bus already released
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> !strb.advance);
  assert_done_released_R11: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |-> !busReq);

  // R10: the bus is released only right after a restore write
  assert_release_after_restore_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(strb.we));

endmodule

// File: rtl/rwcDatapath.sv
module rwcDatapath
  import rwc_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter logic [DATA_W-1:0] PAT_A   = '0,
  parameter logic [DATA_W-1:0] PAT_B   = '1,
  localparam int             KW        = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrb_t           strb,
  input  logic [DATA_W-1:0] ramRdata,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              passDone,
  output logic              failFlag,
  output logic [KW-1:0]     failBit,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failAct
);

  localparam logic [KW-1:0] K_LAST = KW'(ADDR_W - 1);

  logic [KW-1:0]     kQ;
  logic [DATA_W-1:0] saveBase, saveOff;
  logic [ADDR_W-1:0] offAddr;
  logic              kLast, baseBad, offBad;

  assign offAddr = BASE_ADDR + (ADDR_W'(1) << kQ);
  assign ramAddr = strb.selOff ? offAddr : BASE_ADDR;
  assign kLast   = (kQ == K_LAST);

  always_comb begin
    unique case (strb.wsel)
      WSEL_PAT_A:  ramWdata = PAT_A;
      WSEL_PAT_B:  ramWdata = PAT_B;
      WSEL_SAVE_B: ramWdata = saveBase;
      default:     ramWdata = saveOff;
    endcase
  end

  // Bit index with wrap after the top address bit
  always_ff @(posedge clk) begin
    if (!rstN)             kQ <= '0;
    else if (strb.advance) kQ <= kLast ? '0 : kQ + 1'b1;
  end

  assign passDone = strb.advance && kLast;

  always_ff @(posedge clk) begin
    if (strb.capBase) saveBase <= ramRdata;
    if (strb.capOff)  saveOff  <= ramRdata;
  end

  assign baseBad = strb.chkBase && (ramRdata != PAT_A);
  assign offBad  = strb.chkOff  && (ramRdata != PAT_B);

  // First fault wins; compares happen in different cycles
  always_ff @(posedge clk) begin
    if (!rstN) begin
      failFlag <= 1'b0;
      failBit  <= '0;
      failExp  <= '0;
      failAct  <= '0;
    end else if (!failFlag && (baseBad || offBad)) begin
      failFlag <= 1'b1;
      failBit  <= kQ;
      failExp  <= baseBad ? PAT_A : PAT_B;
      failAct  <= ramRdata;
    end
  end

  // R5: index stays in range and is 0 after a pass ends
  assert_k_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    kQ <= K_LAST);
  assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(passDone) |-> (kQ == '0));

  // R9: captured fault is frozen
  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    failFlag |=> (failFlag && $stable(failBit) && $stable(failExp) && $stable(failAct)));

endmodule

// File: rtl/ramWalkChecker.sv
module ramWalkChecker
  import rwc_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter logic [DATA_W-1:0] PAT_A     = '0,
  parameter logic [DATA_W-1:0] PAT_B     = '1,
  localparam int               KW        = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  output logic              busReq,
  input  logic              busGnt,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  output logic              ramWe,
  input  logic [DATA_W-1:0] ramRdata,
  output logic              doneStep,
  output logic              passDone,
  output logic              failFlag,
  output logic [KW-1:0]     failBit,
  output logic [DATA_W-1:0] failExp,
  output logic [DATA_W-1:0] failAct
);

  dpStrb_t strb;

  rwcCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .busGnt     (busGnt),
    .busReq     (busReq),
    .strb       (strb)
  );

  rwcDatapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .BASE_ADDR (BASE_ADDR),
    .PAT_A     (PAT_A),
    .PAT_B     (PAT_B)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .ramRdata (ramRdata),
    .ramAddr  (ramAddr),
    .ramWdata (ramWdata),
    .passDone (passDone),
    .failFlag (failFlag),
    .failBit  (failBit),
    .failExp  (failExp),
    .failAct  (failAct)
  );

  assign ramWe    = strb.we;
  assign doneStep = strb.advance;

endmodule

// File: tb/ramWalkChecker_bench.sv
`timescale 1ns/1ps
module ramWalkChecker_bench;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int KW = 3;
  localparam int NW = 1 << AW;
  localparam logic [DW-1:0] PA = 8'h00;
  localparam logic [DW-1:0] PB = 8'hFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic busReq, busGnt, ramWe, doneStep, passDone, failFlag;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramWdata, ramRdata, rdQ;
  logic [KW-1:0] failBit;
  logic [DW-1:0] failExp, failAct;

  always #2 clk = ~clk;

  ramWalkChecker #(
    .ADDR_W(AW), .DATA_W(DW), .BASE_ADDR(6'd0), .PAT_A(PA), .PAT_B(PB)
  ) u_ramWalkChecker (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .busReq(busReq),
    .busGnt(busGnt), .ramAddr(ramAddr), .ramWdata(ramWdata), .ramWe(ramWe),
    .ramRdata(ramRdata), .doneStep(doneStep), .passDone(passDone),
    .failFlag(failFlag), .failBit(failBit), .failExp(failExp), .failAct(failAct)
  );

  // RAM model with injectable faults
  logic [DW-1:0] mem [NW];
  logic [DW-1:0] shadow [NW];
  logic [AW-1:0] stuckAddr0 = '0;
  logic [DW-1:0] stuckData1 = '0;
  wire  [AW-1:0] effAddr = ramAddr & ~stuckAddr0;

  always @(posedge clk) begin
    if (ramWe) mem[effAddr] <= ramWdata;
    rdQ <= mem[effAddr];
  end
  assign ramRdata = rdQ | stuckData1;

  // Arbiter: grants one cycle after the request
  always @(posedge clk) busGnt <= rstN && busReq;

  // Monitors (never reset; tasks work with differences)
  int wrCnt = 0, badWr = 0, doneCnt = 0, passCnt = 0;
  logic [AW-1:0] wrAddrLog [256];
  logic [DW-1:0] wrDataLog [256];
  always @(posedge clk) begin
    if (rstN && ramWe) begin
      if (!busGnt) badWr <= badWr + 1;
      wrAddrLog[wrCnt[7:0]] <= ramAddr;
      wrDataLog[wrCnt[7:0]] <= ramWdata;
      wrCnt <= wrCnt + 1;
    end
    if (rstN && doneStep) doneCnt <= doneCnt + 1;
    if (rstN && passDone) passCnt <= passCnt + 1;
  end

  int checks = 0, failures = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic fillMem(input int seed);
    for (int i = 0; i < NW; i++) begin
      mem[i]    = 8'((i * 37 + seed) & 8'hFF);
      shadow[i] = mem[i];
    end
  endtask

  // One step; optionally pulse start again mid-step
  task automatic runStep(input bit extraStart, output int lat);
    lat = 0;
    @(negedge clk);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R2 busReq after start", busReq, 1'b1);
    while (!doneStep && lat < 60) begin
      @(negedge clk);
      lat++;
      if (extraStart && lat == 4) startPulse = 1'b1;
      else startPulse = 1'b0;
      if (!doneStep && lat > 1) chk("R10 busReq held", busReq, 1'b1);
    end
    chk("R11 doneStep seen", doneStep, 1'b1);
    chk("R11 busReq low at done", busReq, 1'b0);
    @(negedge clk);
    chk("R11 doneStep one cycle", doneStep, 1'b0);
  endtask

  task automatic memMatches(input string tag);
    int bad = 0;
    for (int i = 0; i < NW; i++) if (mem[i] !== shadow[i]) bad++;
    chk(tag, bad, 0);
  endtask

  task automatic cleanStep(input int k);
    int w0, lat, p0;
    logic [AW-1:0] off;
    off = AW'(1 << k);
    w0 = wrCnt;
    p0 = passCnt;
    runStep(1'b0, lat);
    chk("R4 write count", wrCnt - w0, 4);
    chk("R4 addr pat A", wrAddrLog[w0[7:0]], 0);
    chk("R4 data pat A", wrDataLog[w0[7:0]], PA);
    chk("R4 addr pat B", wrAddrLog[8'(w0 + 1)], off);
    chk("R4 data pat B", wrDataLog[8'(w0 + 1)], PB);
    chk("R4 restore base data", wrDataLog[8'(w0 + 2)], shadow[0]);
    chk("R4 restore off addr", wrAddrLog[8'(w0 + 3)], off);
    chk("R4 restore off data", wrDataLog[8'(w0 + 3)], shadow[off]);
    chk("R5 passDone at wrap only", passCnt - p0, (k == AW - 1) ? 1 : 0);
    memMatches("R3 memory unchanged");
    chk("R2 no write without grant", badWr, 0);
  endtask

  task automatic testReset();
    doReset();
    chk("R1 busReq", busReq, 1'b0);
    chk("R1 doneStep", doneStep, 1'b0);
    chk("R1 passDone", passDone, 1'b0);
    chk("R1 failFlag", failFlag, 1'b0);
  endtask

  task automatic testFullPass();
    fillMem(11);
    for (int k = 0; k < AW; k++) cleanStep(k);
    cleanStep(0);  // R5 wrap back to bit 0
    chk("R7 no fault on good RAM", failFlag, 1'b0);
  endtask

  task automatic testIgnoreStart();
    int d0, w0, lat;
    d0 = doneCnt;
    w0 = wrCnt;
    runStep(1'b1, lat);
    repeat (20) @(negedge clk);
    chk("R6 one done only", doneCnt - d0, 1);
    chk("R6 four writes only", wrCnt - w0, 4);
    chk("R6 bus idle after", busReq, 1'b0);
    cleanStep(2);  // index moved by exactly one (step above used k=1)
  endtask

  task automatic testAddrFault();
    int lat, w0;
    doReset();
    fillMem(5);
    stuckAddr0 = AW'(1 << 2);
    cleanStep(0);
    cleanStep(1);
    w0 = wrCnt;
    runStep(1'b0, lat);
    chk("R7 failFlag", failFlag, 1'b1);
    chk("R7 failBit", failBit, 2);
    chk("R7 failExp", failExp, PA);
    chk("R7 failAct", failAct, PB);
    chk("R10 restores done after fault", wrCnt - w0, 4);
    memMatches("R10 memory restored after fault");
    stuckAddr0 = '0;
    runStep(1'b0, lat);
    runStep(1'b0, lat);
    chk("R9 flag kept", failFlag, 1'b1);
    chk("R9 bit kept", failBit, 2);
    chk("R9 act kept", failAct, PB);
  endtask

  task automatic testDataFault();
    int lat;
    doReset();
    chk("R1 fail cleared by reset", failFlag, 1'b0);
    fillMem(3);
    stuckData1 = 8'h10;
    runStep(1'b0, lat);
    chk("R8 failFlag", failFlag, 1'b1);
    chk("R8 failBit", failBit, 0);
    chk("R8 failExp", failExp, PA);
    chk("R8 failAct", failAct, 8'h10);
    stuckData1 = '0;
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testFullPass();
    testIgnoreStart();
    testAddrFault();
    testDataFault();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule